// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table held in memory. A software-visible root register holds the physical byte address of the top table. Rewriting that register is all a context switch needs to do.

A translation request is split into three fields. The top 10 bits select an entry in the top table. The next 10 bits select an entry in the second table. The low 12 bits are the byte offset within a 4 KiB page. The walker makes two dependent reads through a valid/ready memory read port:

- The first read returns the frame that holds the second table.
- The second read returns the frame of the data page.

The walker then joins that frame with the offset. If either entry is marked absent, the walk stops and the response reports a page fault carrying the virtual address. Only one walk is outstanding at a time.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the root register holds 0, so a walk started before any root write reads its top entry at address `0 + 4*top_index`.
- R2: The first memory read of a walk targets `root + 4*vaddr[31:22]`. The root value used is the one held when the request was accepted.
- R3: When the top entry is present, the second read targets `{top_entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R4: When both entries are present, the response has `rsp_fault = 0` and `rsp_addr = {second_entry[31:12], vaddr[11:0]}`. This is preceded by exactly two memory reads.
- R5: A top entry with bit 0 (present) equal to 0 ends the walk after one read. The response then has `rsp_fault = 1` and `rsp_addr` equal to the request's virtual address. This holds whatever the entry's frame field contains.
- R6: A second entry with bit 0 equal to 0 ends the walk after two reads. The response then has `rsp_fault = 1` and `rsp_addr` equal to the virtual address.
- R7: Between accepting a request and the taking of its response, `req_ready` stays 0. While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and unchanged.
- R8: A read request on the memory port keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is seen.
- R9: A root write during a walk does not change that walk. It applies to every walk accepted after the write cycle.
- R10: Entry bits 11:1 are ignored. They affect neither the addresses read nor the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_we | input | 1 | Write enable for the root register |
| root_wdata | input | 32 | New top-table base address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | 1 when the walk hit an absent entry |
| rsp_addr | output | 32 | Physical address, or the faulting virtual address |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 32 | Table entry read back |

## Verification
The checker monitors protocol and bookkeeping properties on every cycle:

- the reset state;
- that only one walk is outstanding;
- that pending requests and responses are held stable;
- that a fault returns the accepted virtual address;
- that at most two reads happen per walk, and a successful walk uses exactly two;
- that the offset passes through unchanged.

The address arithmetic needs the bench's memory model and its queued expected values:

- the exact table-entry addresses of each read;
- the frame taken from the second entry;
- that junk in entry bits 11:1 is ignored;
- the index extremes;
- whether a root write lands before or after an in-flight walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W        = 32;
    localparam int OFF_W       = 12;
    localparam int IDX_W       = 10;
    localparam int ENTRY_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TOP,
        ST_WT_TOP,
        ST_RD_SEC,
        ST_WT_SEC,
        ST_RESP
    } walk_state_e;

    typedef struct packed {
        logic                   fault;
        logic [VA_W-1:0]        addr;
    } walk_result_t;

    function automatic logic [VA_W-1:0] join_frame_offset(
        input logic [VA_W-OFF_W-1:0] frame,
        input logic [OFF_W-1:0]      offset
    );
        return {frame, offset};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_W        = ptw_pkg::VA_W,
    parameter int OFF_W       = ptw_pkg::OFF_W,
    parameter int IDX_W       = ptw_pkg::IDX_W,
    parameter int ENTRY_BYTES = ptw_pkg::ENTRY_BYTES
) (
    input  logic                    second_level,
    input  logic [VA_W-1:0]         vaddr,
    input  logic [VA_W-1:0]         root_base,
    input  logic [VA_W-OFF_W-1:0]   table_frame,
    output logic [VA_W-1:0]         entry_addr
);
    localparam int SHIFT   = $clog2(ENTRY_BYTES);
    localparam int SEC_LSB = OFF_W;
    localparam int TOP_LSB = OFF_W + IDX_W;

    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] sec_idx;
    logic [IDX_W-1:0] sel_idx;
    logic [VA_W-1:0]  sel_base;
    logic [VA_W-1:0]  idx_bytes;

    assign top_idx = vaddr[TOP_LSB +: IDX_W];
    assign sec_idx = vaddr[SEC_LSB +: IDX_W];

    always_comb begin
        if (second_level) begin
            sel_idx  = sec_idx;
            sel_base = {table_frame, {OFF_W{1'b0}}};
        end else begin
            sel_idx  = top_idx;
            sel_base = root_base;
        end
    end

    generate
        if (SHIFT == 0) begin : g_byte_entries
            assign idx_bytes = VA_W'(sel_idx);
        end else begin : g_wide_entries
            assign idx_bytes = VA_W'({sel_idx, {SHIFT{1'b0}}});
        end
    endgenerate

    assign entry_addr = sel_base + idx_bytes;

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int VA_W  = ptw_pkg::VA_W,
    parameter int OFF_W = ptw_pkg::OFF_W
) (
    input  logic [VA_W-1:0]         entry,
    output logic                    present,
    output logic [VA_W-OFF_W-1:0]   frame
);
    assign present = entry[0];
    assign frame   = entry[VA_W-1:OFF_W];
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        entry_present,
    input  logic        rsp_ready,
    output walk_state_e state
);
    walk_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid)     nxt = ST_RD_TOP;
            ST_RD_TOP: if (mem_req_ready) nxt = ST_WT_TOP;
            ST_WT_TOP: if (mem_rsp_valid) nxt = entry_present ? ST_RD_SEC : ST_RESP;
            ST_RD_SEC: if (mem_req_ready) nxt = ST_WT_SEC;
            ST_WT_SEC: if (mem_rsp_valid) nxt = ST_RESP;
            ST_RESP:   if (rsp_ready)     nxt = ST_IDLE;
            default:                      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int P_VA_W  = VA_W,
    parameter int P_OFF_W = OFF_W,
    parameter int P_IDX_W = IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                root_we,
    input  logic [P_VA_W-1:0]   root_wdata,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [P_VA_W-1:0]   req_vaddr,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic                rsp_fault,
    output logic [P_VA_W-1:0]   rsp_addr,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [P_VA_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    output logic                mem_rsp_ready,
    input  logic [P_VA_W-1:0]   mem_rsp_data
);
    localparam int FRAME_W = P_VA_W - P_OFF_W;

    walk_state_e          state;
    logic [P_VA_W-1:0]    root_q;
    logic [P_VA_W-1:0]    walk_root_q;
    logic [P_VA_W-1:0]    vaddr_q;
    logic [FRAME_W-1:0]   table_frame_q;
    walk_result_t         result_q;
    logic                 pte_present;
    logic [FRAME_W-1:0]   pte_frame;
    logic                 accept;
    logic                 top_back;
    logic                 sec_back;

    assign accept   = req_valid && (state == ST_IDLE);
    assign top_back = mem_rsp_valid && (state == ST_WT_TOP);
    assign sec_back = mem_rsp_valid && (state == ST_WT_SEC);

    ptw_walk_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .entry_present (pte_present),
        .rsp_ready     (rsp_ready),
        .state         (state)
    );

    ptw_addr_gen #(
        .VA_W  (P_VA_W),
        .OFF_W (P_OFF_W),
        .IDX_W (P_IDX_W)
    ) u_addr (
        .second_level (state == ST_RD_SEC),
        .vaddr        (vaddr_q),
        .root_base    (walk_root_q),
        .table_frame  (table_frame_q),
        .entry_addr   (mem_req_addr)
    );

    ptw_pte_decode #(
        .VA_W  (P_VA_W),
        .OFF_W (P_OFF_W)
    ) u_pte (
        .entry   (mem_rsp_data),
        .present (pte_present),
        .frame   (pte_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            root_q        <= '0;
            walk_root_q   <= '0;
            vaddr_q       <= '0;
            table_frame_q <= '0;
            result_q      <= '0;
        end else begin
            if (root_we) root_q <= root_wdata;
            if (accept) begin
                vaddr_q     <= req_vaddr;
                walk_root_q <= root_q;
            end
            if (top_back) begin
                table_frame_q <= pte_frame;
                if (!pte_present) begin
                    result_q.fault <= 1'b1;
                    result_q.addr  <= vaddr_q;
                end
            end
            if (sec_back) begin
                if (pte_present) begin
                    result_q.fault <= 1'b0;
                    result_q.addr  <= join_frame_offset(pte_frame, vaddr_q[P_OFF_W-1:0]);
                end else begin
                    result_q.fault <= 1'b1;
                    result_q.addr  <= vaddr_q;
                end
            end
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_RD_TOP) || (state == ST_RD_SEC);
    assign mem_rsp_ready = (state == ST_WT_TOP) || (state == ST_WT_SEC);
    assign rsp_valid     = (state == ST_RESP);
    assign rsp_fault     = result_q.fault;
    assign rsp_addr      = result_q.addr;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic             rsp_fault,
    input logic [VA_W-1:0]  rsp_addr,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [VA_W-1:0]  mem_req_addr
);
    logic [VA_W-1:0] seen_vaddr;
    logic [1:0]      rd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_vaddr <= '0;
            rd_cnt     <= '0;
        end else if (req_valid && req_ready) begin
            seen_vaddr <= req_vaddr;
            rd_cnt     <= '0;
        end else if (mem_req_valid && mem_req_ready && rd_cnt != 2'd3) begin
            rd_cnt <= rd_cnt + 2'd1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid && !mem_req_valid));

    // R7
    single_walk_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!rsp_valid && !mem_req_valid));

    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R5
    fault_vaddr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_addr == seen_vaddr && rd_cnt != 2'd0));

    // R4
    two_reads_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rd_cnt == 2'd2));

    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_addr[OFF_W-1:0] == seen_vaddr[OFF_W-1:0]));

    // R6
    read_limit_chk: assert property (@(posedge clk) disable iff (rst)
        rd_cnt <= 2'd2);

endmodule

bind ptw_walker ptw_walker_chk #(
    .VA_W  (P_VA_W),
    .OFF_W (P_OFF_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_addr      (rsp_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        root_we = 1'b0;
    logic [31:0] root_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [31:0] rsp_addr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [31:0] mem_rsp_data = '0;

    always #10 clk = ~clk;

    ptw_walker dut_i (
        .clk           (clk),
        .rst           (rst),
        .root_we       (root_we),
        .root_wdata    (root_wdata),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_fault     (rsp_fault),
        .rsp_addr      (rsp_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .mem_rsp_data  (mem_rsp_data)
    );

    typedef struct {
        bit          fault;
        logic [31:0] addr;
        int          nrd;
        logic [31:0] a1;
        logic [31:0] a2;
        string       tag;
    } exp_t;

    logic [31:0] mem [logic [31:0]];
    exp_t        exp_q[$];
    logic [31:0] rd_q[$];
    logic [31:0] root_model = '0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    int          mem_ctr = 0;
    int          mon_ctr = 0;

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic predict(input logic [31:0] va, input string tag);
        exp_t e;
        logic [31:0] p1, p2;
        e.tag   = tag;
        e.a1    = root_model + {20'b0, va[31:22], 2'b00};
        e.a2    = '0;
        p1      = rd_mem(e.a1);
        if (!p1[0]) begin
            e.fault = 1'b1; e.addr = va; e.nrd = 1;
        end else begin
            e.a2 = {p1[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
            p2   = rd_mem(e.a2);
            e.nrd = 2;
            if (!p2[0]) begin
                e.fault = 1'b1; e.addr = va;
            end else begin
                e.fault = 1'b0; e.addr = {p2[31:12], va[11:0]};
            end
        end
        exp_q.push_back(e);
    endtask

    // driver: waits for idle, pushes expectation, completes handshake
    task automatic send(input logic [31:0] va, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        predict(va, tag);
        req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 32'hDEAD_BEEF;
    endtask

    task automatic set_root(input logic [31:0] v);
        @(negedge clk);
        root_we    = 1'b1;
        root_wdata = v;
        @(negedge clk);
        root_we    = 1'b0;
        root_model = v;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // memory responder with varying wait states
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid && !rst) begin
                logic [31:0] a;
                repeat (mem_ctr % 3) @(negedge clk);
                mem_ctr++;
                a = mem_req_addr;
                mem_req_ready = 1'b1;
                rd_q.push_back(a);
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (mem_ctr % 2) @(negedge clk);
                mem_rsp_data  = rd_mem(a);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 32'h0BAD_0000;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid && !rst) begin
                logic [31:0] held_addr;
                logic        held_fault;
                exp_t        e;
                held_addr  = rsp_addr;
                held_fault = rsp_fault;
                repeat (mon_ctr % 3) begin
                    @(negedge clk);
                    check(rsp_valid && rsp_addr == held_addr && rsp_fault == held_fault && !req_ready,
                          "R7", "held response", rsp_addr, held_addr);
                end
                mon_ctr++;
                rsp_ready = 1'b1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected response", rsp_addr, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(rsp_fault == e.fault, e.tag, "fault flag", {31'b0, rsp_fault}, {31'b0, e.fault});
                    check(rsp_addr == e.addr, e.tag, "response address", rsp_addr, e.addr);
                    check(rd_q.size() == e.nrd, e.tag, "read count", rd_q.size(), e.nrd);
                    if (rd_q.size() >= 1)
                        check(rd_q[0] == e.a1, e.tag, "top entry read address", rd_q[0], e.a1);
                    if (rd_q.size() >= 2 && e.nrd == 2)
                        check(rd_q[1] == e.a2, e.tag, "second entry read address", rd_q[1], e.a2);
                end
                rd_q.delete();
                @(negedge clk);
                rsp_ready = 1'b0;
                check(req_ready, "R7", "ready after response taken", {31'b0, req_ready}, 32'h1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // tables under root 0x0001_0000
        mem[32'h0001_0000] = {20'h00040, 11'h000, 1'b1};
        mem[32'h0004_0000] = {20'h12345, 11'h000, 1'b1};
        mem[32'h0001_000C] = {20'h00093, 11'h2AA, 1'b1};
        mem[32'h0009_3008] = {20'h09933, 11'h7FF, 1'b1};
        mem[32'h0009_3020] = {20'h55555, 11'h000, 1'b0};
        mem[32'h0001_0018] = {20'h00093, 11'h000, 1'b0};
        mem[32'h0001_0FFC] = {20'h000AB, 11'h000, 1'b1};
        mem[32'h000A_BFFC] = {20'hFFFFF, 11'h155, 1'b1};
        // tables under root 0x0020_0000
        mem[32'h0020_0000] = {20'h00041, 11'h000, 1'b1};
        mem[32'h0004_1000] = {20'hBEEF0, 11'h000, 1'b1};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        check(req_ready == 1'b1, "R1", "req_ready after reset", {31'b0, req_ready}, 32'h1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", {31'b0, mem_req_valid}, 32'h0);

        // R1 root resets to zero: top read at 0 + 4*2
        send({10'd2, 10'd1, 12'h010}, "R1");
        drain();

        set_root(32'h0001_0000);
        // R2 R3 R4 all-zero indices
        send(32'h0000_0ABC, "R4");
        // R10 junk in entry bits 11:1
        send({10'd3, 10'd2, 12'hF31}, "R10");
        // R2 R3 index extremes
        send(32'hFFFF_FFFF, "R3");
        // R5 top entry absent (not in memory)
        send({10'd5, 10'd9, 12'h123}, "R5");
        // R5 top entry present=0 with a frame value
        send({10'd6, 10'd2, 12'h777}, "R5");
        // R6 second entry missing
        send({10'd3, 10'd7, 12'h001}, "R6");
        // R6 second entry present=0 with a frame value
        send({10'd3, 10'd8, 12'hABC}, "R6");
        drain();

        // R9 root rewritten while a walk is in flight
        send(32'h0000_0ABC, "R9");
        set_root(32'h0020_0000);
        send(32'h0000_0ABC, "R9");
        // R2 top index taken from the new root
        send(32'h0000_0FED, "R2");
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule